// File: doc/BRIEF.md
# MDIO Management Master with Segment Steering

This block is a register-programmed management master for an MDIO bus. Software fills a parameter word (write data, PHY address, Clause 45 select, segment ID and an internal/external flag) and an address word. It then writes an operation code to the control register and polls a done flag. The block derives MDC from the core clock and shifts a complete management frame out on MDIO. For reads it releases the line from the turnaround onward and collects the 16 data bits that the PHY returns.

When Clause 45 is selected, one operation becomes two frames back to back: an address frame that carries the 16-bit register address, then the read or write frame. The parameter word also chooses one of several internal or external MDIO segments. The block raises exactly one segment enable from that choice. It also picks which of two rate registers (internal copy or external copy) sets the MDC speed. A lock bit in the scan register drives an output that keeps an external master off the bus.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset MDC is low, MDIO is not driven (`mdio_oe`=0), status reads 0, both rate registers read 0x0000_0001, the lock output is 0 and only `ext_seg_en[0]` is set.
- R2: A Clause 22 write sends 32 ones, start 01, opcode 01, PHY address (param bits 20:16), register address (address bits 4:0), turnaround 10 and the 16 data bits (param bits 15:0), most significant bit first, each bit held across one MDC period.
- R3: A Clause 22 read sends start 01, opcode 10 and the addresses. It releases MDIO for the turnaround and data bits and samples 16 data bits on rising MDC. The result appears in bits 15:0 of the read-data register, and bits 31:16 read 0.
- R4: With param bit 21 set, an operation sends an address frame first: start 00, opcode 00, PHY address, device address (address bits 20:16), turnaround 10, address bits 15:0. A second frame follows with start 00 and opcode 11 for a read or 01 for a write.
- R5: Status bit 0 (done) becomes 0 when an operation starts or control is written with 0, becomes 1 when the operation finishes, and is never 1 while a frame is in progress.
- R6: Control value 1 starts a write and 2 starts a read. While an operation is in progress, any nonzero control write is ignored. Writing 0 aborts at once: MDC goes low, MDIO is released and done stays 0. Values other than 0, 1 and 2 are ignored at all times.
- R7: The MDC half period is max(divisor,1)·(dividend+1) core clocks. The divisor is in bits 7:0 and the dividend in bits 19:16 of the rate register of the selected path: the internal copy when param bit 25 is set, the external copy otherwise.
- R8: The segment ID is param bits 24:22. With param bit 25 set, only `int_seg_en[ID]` is 1; with bit 25 clear, only `ext_seg_en[ID]` is 1. Exactly one enable is high at all times.
- R9: Bit 28 of the scan register drives `ext_lockout`.
- R10: Word indices are: 0 param, 1 address, 2 control, 3 status, 4 read data, 5 internal rate, 6 external rate, 7 scan. Control reads back the last accepted operation code (0 after an abort).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on `bus_word`) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| int_seg_en | output | NSEG | Internal segment enables |
| ext_seg_en | output | NSEG | External segment enables |
| ext_lockout | output | 1 | Blocks an external master from the bus |

## Verification
The hardest state to reach is a control write that arrives in the middle of a frame. The bench must hit it while MDC is actually toggling and must tell an ignored restart apart from an abort. The bench slows MDC with the rate registers and counts MDC rising edges in a PHY responder. After a chosen number of edges it issues the control write. It then checks that the frame it captured is unchanged, or that the line fell silent with done still low. The two-frame Clause 45 read is the other deep case. The responder decodes the opcode of each frame as it is captured and drives data only in the read frame.

// File: rtl/mgmt_mdio_pkg.sv
// Shared constants and the frame builder for the MDIO management master.
// Assumes frames of 64 bit slots sent most significant bit first.
package mgmt_mdio_pkg;
    localparam int PRM_PHY_LSB = 16;
    localparam int PRM_C45_BIT = 21;
    localparam int PRM_BUS_LSB = 22;
    localparam int PRM_INT_BIT = 25;
    localparam int LOCK_BIT    = 28;
    localparam int DVD_LSB     = 16;
    localparam int FRAME_W     = 64;
    localparam int TA_POS      = 46;
    localparam int DATA_POS    = 48;

    localparam logic [2:0] W_PARAM    = 3'd0;
    localparam logic [2:0] W_ADDR     = 3'd1;
    localparam logic [2:0] W_CTRL     = 3'd2;
    localparam logic [2:0] W_STAT     = 3'd3;
    localparam logic [2:0] W_RDATA    = 3'd4;
    localparam logic [2:0] W_RATE_INT = 3'd5;
    localparam logic [2:0] W_RATE_EXT = 3'd6;
    localparam logic [2:0] W_SCAN     = 3'd7;

    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    // Assemble one management frame, preamble first.
    function automatic logic [FRAME_W-1:0] mk_frame(input logic [1:0] st, input logic [1:0] op,
                                                    input logic [4:0] pa, input logic [4:0] ra,
                                                    input logic [1:0] ta, input logic [15:0] d);
        return {32'hFFFF_FFFF, st, op, pa, ra, ta, d};
    endfunction
endpackage

// File: rtl/mdio_regfile.sv
// Register file: holds parameter, address, control, done, read data, two rate
// copies and the lock bit; decodes control writes into start/abort pulses.
// Assumes one write per cycle and a combinational read port.
module mdio_regfile
    import mgmt_mdio_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DVD_W = 4,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_word,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             eng_busy,
    input  logic             eng_fin,
    input  logic [15:0]      eng_rdata,
    output logic             start,
    output logic             start_read,
    output logic             abort,
    output logic [15:0]      prm_wdata,
    output logic [4:0]       prm_phy,
    output logic             prm_c45,
    output logic [ID_W-1:0]  prm_bus,
    output logic             prm_int,
    output logic [20:0]      txn_addr,
    output logic [DIV_W-1:0] div_sel,
    output logic [DVD_W-1:0] dvd_sel,
    output logic             lock_o,
    output logic             done_o
);
    logic [31:0]      param_q, addr_q;
    logic [1:0]       ctrl_q;
    logic             done_q, lock_q;
    logic [15:0]      rd_q;
    logic [DIV_W-1:0] div_i_q, div_e_q;
    logic [DVD_W-1:0] dvd_i_q, dvd_e_q;
    logic             ctrl_wr, op_ok;

    // Decode control writes into engine commands.
    always_comb begin
        ctrl_wr    = bus_wr && (bus_word == W_CTRL);
        op_ok      = (bus_wdata == 32'(OP_WRITE)) || (bus_wdata == 32'(OP_READ));
        abort      = ctrl_wr && (bus_wdata == 32'd0);
        start      = ctrl_wr && op_ok && !eng_busy;
        start_read = bus_wdata[1];
    end

    // Register updates; later assignments (control writes) win over completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            param_q <= '0;
            addr_q  <= '0;
            ctrl_q  <= '0;
            done_q  <= 1'b0;
            rd_q    <= '0;
            div_i_q <= DIV_W'(1);
            div_e_q <= DIV_W'(1);
            dvd_i_q <= '0;
            dvd_e_q <= '0;
            lock_q  <= 1'b0;
        end else begin
            if (eng_fin) begin
                done_q <= 1'b1;
                if (ctrl_q == OP_READ) rd_q <= eng_rdata;
            end
            if (bus_wr) begin
                case (bus_word)
                    W_PARAM:    param_q <= bus_wdata;
                    W_ADDR:     addr_q  <= bus_wdata;
                    W_CTRL: begin
                        if (abort) begin
                            ctrl_q <= '0;
                            done_q <= 1'b0;
                        end else if (start) begin
                            ctrl_q <= bus_wdata[1:0];
                            done_q <= 1'b0;
                        end
                    end
                    W_RATE_INT: begin
                        div_i_q <= bus_wdata[DIV_W-1:0];
                        dvd_i_q <= bus_wdata[DVD_LSB +: DVD_W];
                    end
                    W_RATE_EXT: begin
                        div_e_q <= bus_wdata[DIV_W-1:0];
                        dvd_e_q <= bus_wdata[DVD_LSB +: DVD_W];
                    end
                    W_SCAN:     lock_q  <= bus_wdata[LOCK_BIT];
                    default: ;
                endcase
            end
        end
    end

    // Read mux over the word index.
    always_comb begin
        bus_rdata = '0;
        case (bus_word)
            W_PARAM:    bus_rdata = param_q;
            W_ADDR:     bus_rdata = addr_q;
            W_CTRL:     bus_rdata[1:0] = ctrl_q;
            W_STAT:     bus_rdata[0] = done_q;
            W_RDATA:    bus_rdata[15:0] = rd_q;
            W_RATE_INT: begin
                bus_rdata[DIV_W-1:0] = div_i_q;
                bus_rdata[DVD_LSB +: DVD_W] = dvd_i_q;
            end
            W_RATE_EXT: begin
                bus_rdata[DIV_W-1:0] = div_e_q;
                bus_rdata[DVD_LSB +: DVD_W] = dvd_e_q;
            end
            default:    bus_rdata[LOCK_BIT] = lock_q;
        endcase
    end

    // Field taps and rate selection by the internal-path flag.
    always_comb begin
        prm_wdata = param_q[15:0];
        prm_phy   = param_q[PRM_PHY_LSB +: 5];
        prm_c45   = param_q[PRM_C45_BIT];
        prm_bus   = param_q[PRM_BUS_LSB +: ID_W];
        prm_int   = param_q[PRM_INT_BIT];
        txn_addr  = addr_q[20:0];
        div_sel   = prm_int ? div_i_q : div_e_q;
        dvd_sel   = prm_int ? dvd_i_q : dvd_e_q;
        lock_o    = lock_q;
        done_o    = done_q;
    end
endmodule

// File: rtl/mdio_clkgen.sv
// Half-period tick generator for MDC. Emits one tick every HALF core clocks
// while run is high; restarts from zero whenever run drops. Assumes half >= 1.
module mdio_clkgen #(
    parameter int HALF_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_q;

    // Tick on the last count of a half period (tolerates a shrinking limit).
    always_comb tick = run && (cnt_q >= half - HALF_W'(1));

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + HALF_W'(1);
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame sequencer: builds one or two frames at start, toggles MDC on each
// tick, shifts bits out on falling MDC and samples read data on rising MDC.
// Assumes start and abort are never high together.
module mdio_frame_engine
    import mgmt_mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        abort,
    input  logic        op_read,
    input  logic        c45,
    input  logic [4:0]  phy,
    input  logic [20:0] addr,
    input  logic [15:0] wdata,
    input  logic        tick,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        fin,
    output logic [15:0] rd_val
);
    logic [FRAME_W-1:0] sh_q, nxt_q, f_c22, f_adr, f_c45;
    logic [5:0]         pos_q;
    logic               pend_q, rdf_q, rdop_q, mdc_q, busy_q, fin_q;
    logic [15:0]        rsh_q;

    // Candidate frames from the latched-at-start fields.
    always_comb begin
        f_c22 = mk_frame(2'b01, op_read ? 2'b10 : 2'b01, phy, addr[4:0],
                         op_read ? 2'b00 : 2'b10, op_read ? 16'h0 : wdata);
        f_adr = mk_frame(2'b00, 2'b00, phy, addr[20:16], 2'b10, addr[15:0]);
        f_c45 = mk_frame(2'b00, op_read ? 2'b11 : 2'b01, phy, addr[20:16],
                         op_read ? 2'b00 : 2'b10, op_read ? 16'h0 : wdata);
    end

    // Sequencing of frames, MDC phase and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0; nxt_q <= '0; pos_q <= '0;
            pend_q <= 1'b0; rdf_q <= 1'b0; rdop_q <= 1'b0;
            mdc_q <= 1'b0; busy_q <= 1'b0; fin_q <= 1'b0; rsh_q <= '0;
        end else begin
            fin_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
                mdc_q  <= 1'b0;
                pend_q <= 1'b0;
            end else if (start) begin
                busy_q <= 1'b1;
                mdc_q  <= 1'b0;
                pos_q  <= '0;
                rdop_q <= op_read;
                rsh_q  <= '0;
                if (c45) begin
                    sh_q <= f_adr; nxt_q <= f_c45; pend_q <= 1'b1; rdf_q <= 1'b0;
                end else begin
                    sh_q <= f_c22; pend_q <= 1'b0; rdf_q <= op_read;
                end
            end else if (busy_q && tick) begin
                if (!mdc_q) begin
                    mdc_q <= 1'b1;
                    if (rdf_q && pos_q >= 6'(DATA_POS)) rsh_q <= {rsh_q[14:0], mdio_i};
                end else begin
                    mdc_q <= 1'b0;
                    if (pos_q == 6'(FRAME_W - 1)) begin
                        if (pend_q) begin
                            sh_q <= nxt_q; pend_q <= 1'b0; rdf_q <= rdop_q; pos_q <= '0;
                        end else begin
                            busy_q <= 1'b0;
                            fin_q  <= 1'b1;
                        end
                    end else begin
                        pos_q <= pos_q + 6'd1;
                        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // Pin drive: released when idle and from turnaround on in read frames.
    always_comb begin
        mdc     = mdc_q;
        busy    = busy_q;
        fin     = fin_q;
        rd_val  = rsh_q;
        mdio_o  = busy_q & sh_q[FRAME_W-1];
        mdio_oe = busy_q && !(rdf_q && pos_q >= 6'(TA_POS));
    end
endmodule

// File: rtl/mgmt_mdio_master.sv
// Top of the MDIO management master: register file, MDC tick generator,
// frame engine and one-hot segment enable decode. Assumes NSEG <= 8 so the
// segment ID fits its 3-bit parameter field.
module mgmt_mdio_master #(
    parameter int DIV_W = 8,
    parameter int DVD_W = 4,
    parameter int NSEG  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [2:0]      bus_word,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            mdc,
    output logic            mdio_o,
    output logic            mdio_oe,
    input  logic            mdio_i,
    output logic [NSEG-1:0] int_seg_en,
    output logic [NSEG-1:0] ext_seg_en,
    output logic            ext_lockout
);
    localparam int ID_W   = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int HALF_W = DIV_W + DVD_W + 1;

    logic             start, start_read, abort, eng_busy, eng_fin, tick, done_q;
    logic [15:0]      eng_rdata, prm_wdata;
    logic [4:0]       prm_phy;
    logic             prm_c45, prm_int;
    logic [ID_W-1:0]  prm_bus;
    logic [20:0]      txn_addr;
    logic [DIV_W-1:0] div_sel, div_eff;
    logic [DVD_W-1:0] dvd_sel;
    logic [HALF_W-1:0] half;

    mdio_regfile #(.DIV_W(DIV_W), .DVD_W(DVD_W), .ID_W(ID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
        .eng_fin(eng_fin), .eng_rdata(eng_rdata), .start(start),
        .start_read(start_read), .abort(abort), .prm_wdata(prm_wdata),
        .prm_phy(prm_phy), .prm_c45(prm_c45), .prm_bus(prm_bus),
        .prm_int(prm_int), .txn_addr(txn_addr), .div_sel(div_sel),
        .dvd_sel(dvd_sel), .lock_o(ext_lockout), .done_o(done_q)
    );

    // Half period = max(divisor,1) * (dividend + 1).
    always_comb begin
        div_eff = (div_sel == '0) ? DIV_W'(1) : div_sel;
        half    = HALF_W'(div_eff) * HALF_W'(dvd_sel) + HALF_W'(div_eff);
    end

    mdio_clkgen #(.HALF_W(HALF_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .half(half), .tick(tick)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .op_read(start_read), .c45(prm_c45), .phy(prm_phy), .addr(txn_addr),
        .wdata(prm_wdata), .tick(tick), .mdio_i(mdio_i), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(eng_busy), .fin(eng_fin),
        .rd_val(eng_rdata)
    );

    // One enable per segment, internal or external side chosen by the flag.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign int_seg_en[g] = prm_int  && (prm_bus == ID_W'(g));
        assign ext_seg_en[g] = !prm_int && (prm_bus == ID_W'(g));
    end
endmodule

// File: rtl/mgmt_mdio_checker.sv
// Property checker for mgmt_mdio_master, attached by bind. Observes pins,
// engine busy/finish and the done flag.
module mgmt_mdio_checker #(
    parameter int NSEG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mdc,
    input logic            mdio_oe,
    input logic            busy,
    input logic            fin,
    input logic            done,
    input logic [NSEG-1:0] int_seg_en,
    input logic [NSEG-1:0] ext_seg_en,
    input logic            bus_wr,
    input logic [2:0]      bus_word,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
    // R5
    done_from_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(fin));
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == 3'd2 && bus_wdata == 32'd0) |=> (!busy && !done && !mdc));
    // R7
    mdc_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(busy));
    // R8
    one_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({int_seg_en, ext_seg_en}) == 1);
    // R3
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word == 3'd4) |-> (bus_rdata[31:16] == 16'h0));
endmodule

bind mgmt_mdio_master mgmt_mdio_checker #(.NSEG(NSEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_oe(mdio_oe), .busy(eng_busy),
    .fin(eng_fin), .done(done_q), .int_seg_en(int_seg_en), .ext_seg_en(ext_seg_en),
    .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/sim_mgmt_mdio_master.sv
// Directed bench with a PHY responder that captures frames on rising MDC
// and returns read data on falling MDC.
module sim_mgmt_mdio_master;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, mdio_i = 1'b1;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        mdc, mdio_o, mdio_oe, ext_lockout;
    logic [7:0]  int_seg_en, ext_seg_en;

    int errors = 0, checks = 0, ncap = 0, oe_bad = 0;
    logic [127:0] cap = '0;
    logic [15:0]  rsp = '0;
    bit           finished = 0;

    mgmt_mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i), .int_seg_en(int_seg_en),
        .ext_seg_en(ext_seg_en), .ext_lockout(ext_lockout)
    );

    always #(CLK_P/2) clk = ~clk;

    // Responder: capture bits; flag a driven line during read turnaround/data.
    always @(posedge mdc) begin
        int p;
        p = ncap % 64;
        if (p >= 46 && cap[p-35] && mdio_oe) oe_bad++;
        cap = {cap[126:0], mdio_o};
        ncap++;
    end

    // Responder: present read data for the next rising edge in read frames.
    always @(negedge mdc) begin
        int p;
        p = ncap % 64;
        if (p >= 48 && cap[p-35]) mdio_i = rsp[63-p];
        else mdio_i = 1'b1;
    end

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_word = w;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd3, s);
            if (s[0]) return;
        end
    endtask

    function automatic logic [31:0] prm(input bit c45, input bit intl, input int bus,
                                        input logic [4:0] pa, input logic [15:0] d);
        return 32'(d) | (32'(pa) << 16) | (32'(c45) << 21) | (32'(bus) << 22) | (32'(intl) << 25);
    endfunction

    function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input bit rdf, input logic [15:0] d);
        return {{32{1'b1}}, st, op, a, b, rdf ? 2'b00 : 2'b10, rdf ? 16'h0 : d};
    endfunction

    task automatic run_op(input logic [31:0] p, input logic [31:0] a, input logic [1:0] op);
        wr(3'd0, p);
        wr(3'd1, a);
        ncap = 0; oe_bad = 0;
        wr(3'd2, 32'(op));
        wait_done();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 mdc", 128'(mdc), 0);
        chk("R1 oe", 128'(mdio_oe), 0);
        rd(3'd3, v); chk("R1 status", 128'(v), 0);
        rd(3'd5, v); chk("R1 rate_int", 128'(v), 1);
        rd(3'd6, v); chk("R1 rate_ext", 128'(v), 1);
        chk("R1 seg", 128'({int_seg_en, ext_seg_en}), 128'h0001);
        chk("R1 lock", 128'(ext_lockout), 0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        run_op(prm(0, 0, 0, 5'h05, 16'hA5C3), 32'h11, 2'd1);
        chk("R2 bits", 128'(ncap), 64);
        chk("R2 frame", 128'(cap[63:0]), 128'(fr(2'b01, 2'b01, 5'h05, 5'h11, 0, 16'hA5C3)));
        rd(3'd3, v); chk("R5 done", 128'(v), 1);
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        rsp = 16'h3C96;
        run_op(prm(0, 0, 0, 5'h1A, 16'h0), 32'h07, 2'd2);
        chk("R3 frame", 128'(cap[63:0]), 128'(fr(2'b01, 2'b10, 5'h1A, 5'h07, 1, 0)));
        chk("R3 released", 128'(oe_bad), 0);
        rd(3'd4, v); chk("R3 rdata", 128'(v), 128'h3C96);
    endtask

    task automatic t_c45();
        logic [31:0] v;
        run_op(prm(1, 0, 0, 5'h03, 16'hBEEF), 32'h0009_1234, 2'd1);
        chk("R4 wr bits", 128'(ncap), 128);
        chk("R4 wr frames", cap, {fr(2'b00, 2'b00, 5'h03, 5'h09, 0, 16'h1234),
                                  fr(2'b00, 2'b01, 5'h03, 5'h09, 0, 16'hBEEF)});
        rsp = 16'h5AA1;
        run_op(prm(1, 0, 0, 5'h1F, 16'h0), 32'h001E_8001, 2'd2);
        chk("R4 rd frames", cap, {fr(2'b00, 2'b00, 5'h1F, 5'h1E, 0, 16'h8001),
                                  fr(2'b00, 2'b11, 5'h1F, 5'h1E, 1, 0)});
        chk("R4 released", 128'(oe_bad), 0);
        rd(3'd4, v); chk("R4 rdata", 128'(v), 128'h5AA1);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        rsp = 16'hC0DE;
        wr(3'd0, prm(0, 0, 0, 5'h02, 16'h0));
        wr(3'd1, 32'h04);
        ncap = 0;
        wr(3'd2, 32'd2);
        rd(3'd3, v); chk("R5 done cleared at start", 128'(v), 0);
        repeat (3) @(posedge mdc);
        wr(3'd2, 32'd1);
        wait_done();
        chk("R6 ignored restart", 128'(cap[63:0]), 128'(fr(2'b01, 2'b10, 5'h02, 5'h04, 1, 0)));
        rd(3'd2, v); chk("R10 ctrl readback", 128'(v), 2);
        rd(3'd4, v); chk("R6 rdata", 128'(v), 128'hC0DE);
        ncap = 0;
        wr(3'd2, 32'd3);
        repeat (40) @(negedge clk);
        rd(3'd2, v); chk("R6 value 3 ignored ctrl", 128'(v), 2);
        rd(3'd3, v); chk("R6 value 3 ignored done", 128'(v), 1);
        chk("R6 value 3 no mdc", 128'(ncap), 0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int n0;
        wr(3'd6, 32'h0000_0003);
        wr(3'd0, prm(0, 0, 0, 5'h01, 16'hFFFF));
        ncap = 0;
        wr(3'd2, 32'd1);
        repeat (5) @(posedge mdc);
        wr(3'd2, 32'd0);
        chk("R6 abort mdc", 128'(mdc), 0);
        chk("R6 abort oe", 128'(mdio_oe), 0);
        n0 = ncap;
        repeat (400) @(negedge clk);
        chk("R6 abort silent", 128'(ncap), 128'(n0));
        rd(3'd3, v); chk("R6 abort done", 128'(v), 0);
        rd(3'd2, v); chk("R10 ctrl after abort", 128'(v), 0);
    endtask

    task automatic period(input string rq, input int exp_clk);
        realtime t0, t1;
        wr(3'd2, 32'd1);
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        chk(rq, 128'(int'((t1 - t0) / CLK_P)), 128'(exp_clk));
        wait_done();
    endtask

    task automatic t_rate();
        wr(3'd5, 32'h0001_0003);
        wr(3'd6, 32'h0000_0002);
        wr(3'd0, prm(0, 1, 0, 5'h0, 16'h0));
        period("R7 internal 3x2", 12);
        wr(3'd0, prm(0, 0, 0, 5'h0, 16'h0));
        period("R7 external 2x1", 4);
        wr(3'd6, 32'h0002_0000);
        period("R7 divisor zero", 6);
    endtask

    task automatic t_seg_lock();
        wr(3'd0, prm(0, 1, 5, 5'h0, 16'h0));
        chk("R8 internal id5", 128'({int_seg_en, ext_seg_en}), 128'h2000);
        wr(3'd0, prm(0, 0, 3, 5'h0, 16'h0));
        chk("R8 external id3", 128'({int_seg_en, ext_seg_en}), 128'h0008);
        wr(3'd7, 32'h1000_0000);
        chk("R9 lock set", 128'(ext_lockout), 1);
        wr(3'd7, 32'h0);
        chk("R9 lock clear", 128'(ext_lockout), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_c22_write();
        t_c22_read();
        t_c45();
        t_ignore();
        t_abort();
        t_rate();
        t_seg_lock();
        summary();
    end

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end
endmodule